// File: doc/BRIEF.md
# Split-Transaction Read Requester Tracker

This block is the requester side of a shared parallel bus on which reads are split. A local client hands it a read with a byte count. The block raises a bus request and waits for the grant. It then drives a one-cycle attribute phase that carries a tag, the byte count and the requester's own bus/device/function identity. The target then answers in one of two ways. It may give a split response: the block records the read in an outstanding table and gives up the bus on the next clock edge. It may instead return the data at once: the read then finishes in place and uses no table entry.

Any number of reads, up to the table depth, can be pending at the same time. New reads are accepted while older ones wait. Completion beats arrive later from the completer, addressed by tag and requester identity. Each beat is matched directly to its table slot, and each beat stands for four bytes. An entry retires when its last expected beat arrives. A beat that matches no live entry raises a sticky error flag and changes nothing.

Top module: `split_req_tracker`

## Requirements
- R1: After reset, rd_ready is 1, and bus_req, bus_own, attr_valid, imm_done, retire_valid and unexp_err are all 0.
- R2: Once a read is accepted (rd_valid and rd_ready high at a clock edge), bus_req stays high until bus_gnt is sampled high. In the next cycle attr_valid is high for exactly one cycle, with attr_tag, attr_bytes (the accepted byte count) and attr_rid equal to own_rid.
- R3: A target response sampled while the block owns the bus and waits for a response makes bus_own drop on that edge. When tgt_resp_split=1 the read is entered in the table, and rd_ready returns in the same cycle if the table still has room.
- R4: While earlier reads are pending, a new read is accepted and issued with a different tag.
- R5: A tag is {generation, slot}. The slot is the lowest free table index (low 3 bits). The generation is the slot's 2-bit count of retirements (upper bits), which wraps.
- R6: With 8 entries pending, rd_ready is 0. rd_valid is then ignored: bus_req stays low.
- R7: A read of N bytes (1 to 4095) expects ceil(N/4) completion beats. On the cycle after the last beat, retire_valid pulses with retire_tag equal to the entry's tag. Earlier beats produce no pulse.
- R8: A beat is rejected when its slot is free, its generation is stale, or cpl_rid differs from own_rid. A rejected beat sets unexp_err, which then stays 1, and leaves every entry unchanged.
- R9: A response with tgt_resp_split=0 pulses imm_done in the next cycle and allocates no entry, so the next read reuses the same tag.
- R10: A completion beat on the same edge as a split allocation is handled independently of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_rid | input | 16 | Requester identity: bus, device, function |
| rd_valid | input | 1 | Client read request |
| rd_bytes | input | 12 | Byte count of the read, 1 to 4095 |
| rd_ready | output | 1 | Read can be accepted this cycle |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Bus grant |
| bus_own | output | 1 | Block drives the bus (attribute phase or awaiting response) |
| attr_valid | output | 1 | Attribute phase cycle |
| attr_tag | output | 5 | Tag of the read being issued |
| attr_bytes | output | 12 | Byte count of the read being issued |
| attr_rid | output | 16 | Requester identity in the attribute phase |
| tgt_resp_valid | input | 1 | Target response present |
| tgt_resp_split | input | 1 | 1 = split response, 0 = data returned at once |
| imm_done | output | 1 | Pulse: read finished without splitting |
| cpl_valid | input | 1 | One completion data beat |
| cpl_tag | input | 5 | Tag carried by the completion |
| cpl_rid | input | 16 | Requester identity the completion is addressed to |
| retire_valid | output | 1 | Pulse: an entry finished |
| retire_tag | output | 5 | Tag of the retired entry |
| unexp_err | output | 1 | Sticky unexpected-completion flag |

## Verification
The hardest case to reach is a completion beat that lands on the very edge where the sequencer writes a new entry. The same case must also arise while the table is nearly full and while slot generations have wrapped. The issue task can therefore inject a completion beat during the response cycle. A fixed-seed random phase interleaves reads, immediate responses, correct beats and bogus beats long enough that every slot retires several times, so that stale-generation tags occur naturally.

// File: rtl/srt_pkg.sv
package srt_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ARB  = 2'd1,
        SQ_ATTR = 2'd2,
        SQ_WAIT = 2'd3
    } sq_state_e;
endpackage

// File: rtl/rtr_slot_pick.sv
// Lowest-index free slot finder for the outstanding table.
module rtr_slot_pick #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [DEPTH-1:0] vld_i,
    output logic [IDX_W-1:0] free_idx_o,
    output logic             full_o
);
    always_comb begin
        free_idx_o = '0;
        full_o     = 1'b1;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_i[i]) begin
                free_idx_o = IDX_W'(i);
                full_o     = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rtr_entry.sv
// One outstanding-table slot: valid, generation and remaining beat count.
module rtr_entry #(
    parameter int GEN_W = 2,
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic [CNT_W-1:0] beats_i,
    input  logic             beat_i,
    output logic             valid_o,
    output logic [GEN_W-1:0] gen_o,
    output logic             last_o
);
    typedef struct packed {
        logic             vld;
        logic [GEN_W-1:0] gen;
        logic [CNT_W-1:0] left;
    } ent_t;

    ent_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (alloc_i) begin
            ent_d.vld  = 1'b1;
            ent_d.left = beats_i;
        end else if (beat_i && ent_q.vld) begin
            if (ent_q.left == CNT_W'(1)) begin
                ent_d.vld = 1'b0;
                ent_d.gen = ent_q.gen + GEN_W'(1);
            end else begin
                ent_d.left = ent_q.left - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign valid_o = ent_q.vld;
    assign gen_o   = ent_q.gen;
    assign last_o  = ent_q.vld && (ent_q.left == CNT_W'(1));
endmodule

// File: rtl/rtr_seq.sv
// Request sequencer: arbitration request, attribute phase, response handling.
module rtr_seq
    import srt_pkg::*;
#(
    parameter int BC_W  = 12,
    parameter int TAG_W = 5,
    parameter int IDX_W = 3,
    localparam int GEN_W = TAG_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_valid_i,
    input  logic [BC_W-1:0]  rd_bytes_i,
    output logic             rd_ready_o,
    input  logic             full_i,
    input  logic [IDX_W-1:0] free_idx_i,
    input  logic [GEN_W-1:0] free_gen_i,
    output logic             bus_req_o,
    input  logic             bus_gnt_i,
    output logic             bus_own_o,
    output logic             attr_valid_o,
    output logic [TAG_W-1:0] attr_tag_o,
    output logic [BC_W-1:0]  attr_bytes_o,
    input  logic             resp_valid_i,
    input  logic             resp_split_i,
    output logic             alloc_o,
    output logic [IDX_W-1:0] alloc_idx_o,
    output logic [BC_W-1:0]  alloc_bytes_o,
    output logic             imm_done_o
);
    typedef struct packed {
        sq_state_e        st;
        logic [BC_W-1:0]  bytes;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
        logic             imm;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d     = sq_q;
        sq_d.imm = 1'b0;
        alloc_o  = 1'b0;
        case (sq_q.st)
            SQ_IDLE: begin
                if (rd_valid_i && !full_i) begin
                    sq_d.st    = SQ_ARB;
                    sq_d.bytes = rd_bytes_i;
                    sq_d.idx   = free_idx_i;
                    sq_d.tag   = {free_gen_i, free_idx_i};
                end
            end
            SQ_ARB: begin
                if (bus_gnt_i) sq_d.st = SQ_ATTR;
            end
            SQ_ATTR: begin
                sq_d.st = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (resp_valid_i) begin
                    sq_d.st = SQ_IDLE;
                    if (resp_split_i) alloc_o  = 1'b1;
                    else              sq_d.imm = 1'b1;
                end
            end
            default: sq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= '{st: SQ_IDLE, default: '0};
        else        sq_q <= sq_d;
    end

    assign rd_ready_o    = (sq_q.st == SQ_IDLE) && !full_i;
    assign bus_req_o     = (sq_q.st == SQ_ARB);
    assign bus_own_o     = (sq_q.st == SQ_ATTR) || (sq_q.st == SQ_WAIT);
    assign attr_valid_o  = (sq_q.st == SQ_ATTR);
    assign attr_tag_o    = sq_q.tag;
    assign attr_bytes_o  = sq_q.bytes;
    assign alloc_idx_o   = sq_q.idx;
    assign alloc_bytes_o = sq_q.bytes;
    assign imm_done_o    = sq_q.imm;
endmodule

// File: rtl/split_req_tracker.sv
// Requester-side split-read tracker: sequencer, outstanding table, completion match.
module split_req_tracker #(
    parameter int DEPTH      = 8,
    parameter int TAG_W      = 5,
    parameter int BC_W       = 12,
    parameter int RID_W      = 16,
    parameter int BEAT_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RID_W-1:0] own_rid,
    input  logic             rd_valid,
    input  logic [BC_W-1:0]  rd_bytes,
    output logic             rd_ready,
    output logic             bus_req,
    input  logic             bus_gnt,
    output logic             bus_own,
    output logic             attr_valid,
    output logic [TAG_W-1:0] attr_tag,
    output logic [BC_W-1:0]  attr_bytes,
    output logic [RID_W-1:0] attr_rid,
    input  logic             tgt_resp_valid,
    input  logic             tgt_resp_split,
    output logic             imm_done,
    input  logic             cpl_valid,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic [RID_W-1:0] cpl_rid,
    output logic             retire_valid,
    output logic [TAG_W-1:0] retire_tag,
    output logic             unexp_err
);
    localparam int IDX_W   = $clog2(DEPTH);
    localparam int GEN_W   = TAG_W - IDX_W;
    localparam int BEAT_SH = $clog2(BEAT_BYTES);
    localparam int CNT_W   = BC_W - BEAT_SH + 1;

    logic [DEPTH-1:0]            entry_vld;
    logic [DEPTH-1:0]            entry_last;
    logic [DEPTH-1:0][GEN_W-1:0] entry_gen;
    logic [DEPTH-1:0]            entry_beat;

    logic [IDX_W-1:0] free_idx;
    logic             tbl_full;
    logic             seq_alloc;
    logic [IDX_W-1:0] seq_alloc_idx;
    logic [BC_W-1:0]  seq_alloc_bytes;
    logic [BC_W:0]    bytes_rounded;
    logic [CNT_W-1:0] alloc_beats;

    rtr_slot_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) pick_i (
        .vld_i      (entry_vld),
        .free_idx_o (free_idx),
        .full_o     (tbl_full)
    );

    rtr_seq #(.BC_W(BC_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_valid_i    (rd_valid),
        .rd_bytes_i    (rd_bytes),
        .rd_ready_o    (rd_ready),
        .full_i        (tbl_full),
        .free_idx_i    (free_idx),
        .free_gen_i    (entry_gen[free_idx]),
        .bus_req_o     (bus_req),
        .bus_gnt_i     (bus_gnt),
        .bus_own_o     (bus_own),
        .attr_valid_o  (attr_valid),
        .attr_tag_o    (attr_tag),
        .attr_bytes_o  (attr_bytes),
        .resp_valid_i  (tgt_resp_valid),
        .resp_split_i  (tgt_resp_split),
        .alloc_o       (seq_alloc),
        .alloc_idx_o   (seq_alloc_idx),
        .alloc_bytes_o (seq_alloc_bytes),
        .imm_done_o    (imm_done)
    );

    assign attr_rid = own_rid;

    // Beats expected: byte count rounded up to whole beats.
    assign bytes_rounded = {1'b0, seq_alloc_bytes} + (BC_W + 1)'(BEAT_BYTES - 1);
    assign alloc_beats   = bytes_rounded[BC_W:BEAT_SH];

    // Completion decode: low tag bits select the slot, high bits the generation.
    logic [IDX_W-1:0] cpl_idx;
    logic [GEN_W-1:0] cpl_gen;
    logic             cpl_hit;

    assign cpl_idx = cpl_tag[IDX_W-1:0];
    assign cpl_gen = cpl_tag[TAG_W-1:IDX_W];
    assign cpl_hit = cpl_valid && entry_vld[cpl_idx]
                  && (entry_gen[cpl_idx] == cpl_gen) && (cpl_rid == own_rid);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign entry_beat[g] = cpl_hit && (cpl_idx == IDX_W'(g));
        rtr_entry #(.GEN_W(GEN_W), .CNT_W(CNT_W)) ent_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .alloc_i (seq_alloc && (seq_alloc_idx == IDX_W'(g))),
            .beats_i (alloc_beats),
            .beat_i  (entry_beat[g]),
            .valid_o (entry_vld[g]),
            .gen_o   (entry_gen[g]),
            .last_o  (entry_last[g])
        );
    end

    typedef struct packed {
        logic             ret;
        logic [TAG_W-1:0] rtag;
        logic             err;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d      = out_q;
        out_d.ret  = cpl_hit && entry_last[cpl_idx];
        out_d.rtag = cpl_tag;
        out_d.err  = out_q.err || (cpl_valid && !cpl_hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign retire_valid = out_q.ret;
    assign retire_tag   = out_q.rtag;
    assign unexp_err    = out_q.err;
endmodule

// File: rtl/srt_checker.sv
// Protocol checks for split_req_tracker, attached with bind.
module srt_checker #(
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_gnt,
    input logic             bus_own,
    input logic             attr_valid,
    input logic             rd_ready,
    input logic             tgt_resp_valid,
    input logic             unexp_err,
    input logic [DEPTH-1:0] entry_vld
);
    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req);

    assert_attr_after_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        attr_valid |-> $past(bus_req && bus_gnt));

    assert_attr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        attr_valid |=> !attr_valid);

    assert_req_own_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_req, bus_own}));

    assert_bus_freed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own && !attr_valid && tgt_resp_valid |=> !bus_own);

    assert_no_issue_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> ($countones(entry_vld) < DEPTH));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unexp_err |=> unexp_err);
endmodule

bind split_req_tracker srt_checker #(.DEPTH(DEPTH)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_req        (bus_req),
    .bus_gnt        (bus_gnt),
    .bus_own        (bus_own),
    .attr_valid     (attr_valid),
    .rd_ready       (rd_ready),
    .tgt_resp_valid (tgt_resp_valid),
    .unexp_err      (unexp_err),
    .entry_vld      (entry_vld)
);

// File: tb/split_req_tracker_tb_top.sv
`timescale 1ns/1ps
module split_req_tracker_tb_top;
    localparam int OWN = 16'h3A5C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] own_rid = 16'(OWN);
    logic        rd_valid = 1'b0;
    logic [11:0] rd_bytes = '0;
    logic        rd_ready;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic        bus_own;
    logic        attr_valid;
    logic [4:0]  attr_tag;
    logic [11:0] attr_bytes;
    logic [15:0] attr_rid;
    logic        tgt_resp_valid = 1'b0;
    logic        tgt_resp_split = 1'b0;
    logic        imm_done;
    logic        cpl_valid = 1'b0;
    logic [4:0]  cpl_tag = '0;
    logic [15:0] cpl_rid = '0;
    logic        retire_valid;
    logic [4:0]  retire_tag;
    logic        unexp_err;

    always #2.5 clk = ~clk;

    split_req_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .own_rid(own_rid),
        .rd_valid(rd_valid), .rd_bytes(rd_bytes), .rd_ready(rd_ready),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_own(bus_own),
        .attr_valid(attr_valid), .attr_tag(attr_tag), .attr_bytes(attr_bytes),
        .attr_rid(attr_rid), .tgt_resp_valid(tgt_resp_valid),
        .tgt_resp_split(tgt_resp_split), .imm_done(imm_done),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_rid(cpl_rid),
        .retire_valid(retire_valid), .retire_tag(retire_tag), .unexp_err(unexp_err)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Reference model of the table.
    bit m_vld [8];
    int m_gen [8];
    int m_left[8];
    bit m_err = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int beats_of(input int b);
        return (b + 3) / 4;
    endfunction

    function automatic int free_slot();
        for (int i = 0; i < 8; i++) if (!m_vld[i]) return i;
        return -1;
    endfunction

    function automatic int tag_of(input int s);
        return (m_gen[s] % 4) * 8 + s;
    endfunction

    function automatic int n_pending();
        int n = 0;
        for (int i = 0; i < 8; i++) if (m_vld[i]) n++;
        return n;
    endfunction

    function automatic int random_live_tag();
        int s = $urandom % 8;
        for (int k = 0; k < 8; k++) begin
            if (m_vld[(s + k) % 8]) return tag_of((s + k) % 8);
        end
        return -1;
    endfunction

    // Model one completion beat; returns 1 when it retires an entry.
    function automatic bit model_beat(input int tag, input int rid);
        int s = tag % 8;
        int g = tag / 8;
        if (m_vld[s] && (m_gen[s] % 4) == g && rid == OWN) begin
            if (m_left[s] == 1) begin
                m_vld[s] = 1'b0;
                m_gen[s]++;
                return 1'b1;
            end
            m_left[s]--;
            return 1'b0;
        end
        m_err = 1'b1;
        return 1'b0;
    endfunction

    task automatic beat(input int tag, input int rid, input string req);
        bit ret;
        cpl_valid = 1'b1;
        cpl_tag   = 5'(tag);
        cpl_rid   = 16'(rid);
        tick();
        cpl_valid = 1'b0;
        ret = model_beat(tag, rid);
        check({req, " retire_valid"}, int'(retire_valid), int'(ret));
        if (ret) check({req, " retire_tag"}, int'(retire_tag), tag);
        check({req, " unexp_err"}, int'(unexp_err), int'(m_err));
    endtask

    // Issue one read; optionally inject a completion beat on the response edge.
    task automatic issue(input int b, input bit split, input int dly,
                         input bit cbeat, input int ctag);
        int  s;
        int  etag;
        bit  ret;
        s = free_slot();
        etag = tag_of(s);
        check("R6 rd_ready before issue", int'(rd_ready), 1);
        rd_valid = 1'b1;
        rd_bytes = 12'(b);
        tick();
        rd_valid = 1'b0;
        for (int i = 0; i < dly; i++) begin
            check("R2 bus_req held without grant", int'(bus_req), 1);
            tick();
        end
        check("R2 bus_req before grant", int'(bus_req), 1);
        check("R2 no attr before grant", int'(attr_valid), 0);
        bus_gnt = 1'b1;
        tick();
        bus_gnt = 1'b0;
        check("R2 attr_valid", int'(attr_valid), 1);
        check("R5 attr_tag", int'(attr_tag), etag);
        check("R2 attr_bytes", int'(attr_bytes), b);
        check("R2 attr_rid", int'(attr_rid), OWN);
        check("R2 bus_req dropped", int'(bus_req), 0);
        tick();
        check("R2 attr one cycle", int'(attr_valid), 0);
        check("R3 bus_own while waiting", int'(bus_own), 1);
        tgt_resp_valid = 1'b1;
        tgt_resp_split = split;
        if (cbeat) begin
            cpl_valid = 1'b1;
            cpl_tag   = 5'(ctag);
            cpl_rid   = 16'(OWN);
        end
        tick();
        tgt_resp_valid = 1'b0;
        cpl_valid      = 1'b0;
        ret = 1'b0;
        if (cbeat) ret = model_beat(ctag, OWN);
        if (split) begin
            m_vld[s]  = 1'b1;
            m_left[s] = beats_of(b);
        end
        check("R3 bus freed after response", int'(bus_own), 0);
        check("R9 imm_done", int'(imm_done), int'(!split));
        check("R3 rd_ready after response", int'(rd_ready), int'(n_pending() < 8));
        if (cbeat) begin
            check("R10 retire with concurrent alloc", int'(retire_valid), int'(ret));
            if (ret) check("R10 retire_tag", int'(retire_tag), ctag);
            check("R10 unexp_err", int'(unexp_err), int'(m_err));
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int t0;
        int t1;
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 8; i++) begin
            m_vld[i] = 1'b0; m_gen[i] = 0; m_left[i] = 0;
        end
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rd_ready", int'(rd_ready), 1);
        check("R1 bus_req", int'(bus_req), 0);
        check("R1 bus_own", int'(bus_own), 0);
        check("R1 attr_valid", int'(attr_valid), 0);
        check("R1 imm_done", int'(imm_done), 0);
        check("R1 retire_valid", int'(retire_valid), 0);
        check("R1 unexp_err", int'(unexp_err), 0);

        // R2/R3: grant delayed by 3 cycles, 8 bytes -> 2 beats
        issue(8, 1'b1, 3, 1'b0, 0);
        t0 = 0;
        // R4: second read while first pending, 5 bytes -> 2 beats
        issue(5, 1'b1, 0, 1'b0, 0);
        t1 = 1;
        check("R4 two pending tags differ", int'(t0 != t1), 1);

        // R8: wrong requester id -> error, entry untouched
        beat(t0, OWN ^ 16'h0100, "R8 wrong rid");
        check("R8 error set", int'(unexp_err), 1);
        // R7: slot 1 needs two beats
        beat(t1, OWN, "R7 first beat no retire");
        beat(t1, OWN, "R7 last beat retires");
        // R8: stale generation for slot 1 and free slot 5
        beat(t1, OWN, "R8 stale generation");
        beat(5, OWN, "R8 free slot");
        // R8: slot 0 still wants exactly two beats
        beat(t0, OWN, "R8 entry unchanged first");
        beat(t0, OWN, "R8 entry unchanged last");
        check("R8 error still set", int'(unexp_err), 1);

        // R9: immediate data, tag reused by the next read
        issue(16, 1'b0, 1, 1'b0, 0);
        check("R9 no entry allocated", int'(rd_ready), 1);
        issue(4, 1'b1, 0, 1'b0, 0);   // attr_tag checked against same slot/gen

        // R6: fill the table
        while (free_slot() >= 0) issue(12, 1'b1, 0, 1'b0, 0);
        check("R6 rd_ready when full", int'(rd_ready), 0);
        rd_valid = 1'b1;
        rd_bytes = 12'd4;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R6 request ignored when full", int'(bus_req), 0);
        end
        rd_valid = 1'b0;
        // free slot 0 (one beat of 4 bytes entry)
        beat(tag_of(0), OWN, "R7 free slot 0");
        beat(tag_of(0), OWN, "R7 free slot 0");
        beat(tag_of(0), OWN, "R7 free slot 0");
        // R10: allocation with a completion beat on the same edge
        issue(4, 1'b1, 0, 1'b1, tag_of(3));

        // Random phase
        for (int it = 0; it < 600; it++) begin
            int r = $urandom % 10;
            int lt = random_live_tag();
            if (r < 4 && free_slot() >= 0) begin
                int b = ($urandom % 6 == 0) ? 1 + $urandom % 200 : 1 + $urandom % 24;
                bit sp = ($urandom % 6) != 0;
                bit cb = (lt >= 0) && ($urandom % 3 == 0);
                issue(b, sp, $urandom % 3, cb, (lt >= 0) ? lt : 0);
            end else if (lt >= 0 && r != 9) begin
                beat(lt, OWN, "R7 random beat");
            end else begin
                beat($urandom % 32, ($urandom % 2) ? OWN : OWN + 1, "R8 random beat");
            end
        end

        // Drain
        for (int s = 0; s < 8; s++) begin
            while (m_vld[s]) beat(tag_of(s), OWN, "R7 drain");
        end
        check("R6 rd_ready after drain", int'(rd_ready), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule